// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block renames a group of up to two instructions per clock. It translates their architectural register numbers into physical register tags. Each instruction that writes a register gets a fresh physical tag, so two writers of one register never share storage. That removes false write-after-write and write-after-read conflicts before the instructions reach scheduling. The block also reports the tag that the destination pointed at before the rename, so that a later retirement stage can hand it back.

The state is a mapping table and a first-in first-out list of free physical tags. Slot 0 is older in program order than slot 1, and the rename results are combinational in the cycle the group is presented. The table and the free list update at the next rising edge. A release port hands up to two tags per cycle back to the tail of the free list. When the group needs more fresh tags than the free list holds at the start of the cycle, the whole group is held back.

Top module: `rename2_stage`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, so a read of register i returns tag i.
- R2: Every renamed slot with write enable and a nonzero destination receives the tag at the head of the free list. Slot 0 takes it before slot 1. After reset the list holds tags ARCH_N up to PHYS_N-1 in ascending order.
- R3: When both slots write the same register, they receive different tags, and the table ends up holding slot 1's tag.
- R4: A slot 1 source naming slot 0's renamed destination returns the tag just given to slot 0, not the table entry.
- R5: Any other source returns the tag of the most recent earlier renamed writer of that register.
- R6: The previous-tag output of an allocating slot is the mapping its destination had just before that slot. For slot 1 after a same-register slot 0, this is slot 0's new tag.
- R7: Register 0 is never renamed. A source of register 0 returns tag 0. A write to register 0 allocates nothing, and its destination and previous-tag outputs are 0.
- R8: Stall is raised when the number of allocating slots exceeds the free-tag count at the start of the cycle. In that case neither slot is renamed, and both the table and the free list stay unchanged.
- R9: Released tags join the tail of the free list, the tag on release port 0 ahead of the tag on port 1. They are handed out again in that order.
- R10: A slot's ok output is its valid input with stall low. A slot that does not allocate drives 0 on its destination and previous-tag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s0_valid_i | input | 1 | Slot 0 (older) carries an instruction |
| s0_src_a_i | input | AW | Slot 0 first source register |
| s0_src_b_i | input | AW | Slot 0 second source register |
| s0_dst_i | input | AW | Slot 0 destination register |
| s0_wen_i | input | 1 | Slot 0 writes its destination |
| s1_valid_i | input | 1 | Slot 1 (younger) carries an instruction |
| s1_src_a_i | input | AW | Slot 1 first source register |
| s1_src_b_i | input | AW | Slot 1 second source register |
| s1_dst_i | input | AW | Slot 1 destination register |
| s1_wen_i | input | 1 | Slot 1 writes its destination |
| rel0_en_i | input | 1 | Release port 0 carries a tag |
| rel0_tag_i | input | PW | Tag returned on port 0 |
| rel1_en_i | input | 1 | Release port 1 carries a tag |
| rel1_tag_i | input | PW | Tag returned on port 1 |
| stall_o | output | 1 | Group held back for lack of free tags |
| s0_ok_o | output | 1 | Slot 0 renamed this cycle |
| s0_src_a_tag_o | output | PW | Slot 0 first source tag |
| s0_src_b_tag_o | output | PW | Slot 0 second source tag |
| s0_dst_tag_o | output | PW | Slot 0 new destination tag |
| s0_prev_tag_o | output | PW | Slot 0 prior destination mapping |
| s1_ok_o | output | 1 | Slot 1 renamed this cycle |
| s1_src_a_tag_o | output | PW | Slot 1 first source tag |
| s1_src_b_tag_o | output | PW | Slot 1 second source tag |
| s1_dst_tag_o | output | PW | Slot 1 new destination tag |
| s1_prev_tag_o | output | PW | Slot 1 prior destination mapping |

## Verification
The properties assume that only tags currently in flight are released, namely tags previously reported as a previous mapping. They also assume that no tag is released twice and that tag 0 is never released. Under those assumptions the free list can never overflow, and fresh tags stay distinct and nonzero. The stimulus enforces this by releasing only tags taken from its own queue of reported previous mappings. It also keeps all slots idle until the internal reset release has passed. Random groups draw register numbers from a small range, so that same-register pairs, slot 1 reads of slot 0's destination and exhaustion of the free list all occur often.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_ARCH_N = 32;
  localparam int unsigned DEF_PHYS_N = 64;
  localparam int unsigned SLOTS      = 2;
  localparam int unsigned RD_PORTS   = 3 * SLOTS;
endpackage

// File: rtl/rename_maptable.sv
module rename_maptable #(
  parameter int unsigned ARCH_N = rename_pkg::DEF_ARCH_N,
  parameter int unsigned PHYS_N = rename_pkg::DEF_PHYS_N,
  parameter int unsigned NRD    = rename_pkg::RD_PORTS,
  localparam int unsigned AW    = $clog2(ARCH_N),
  localparam int unsigned PW    = $clog2(PHYS_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i [NRD],
  output logic [PW-1:0] rd_tag_o [NRD],
  input  logic          wr_en_i  [rename_pkg::SLOTS],
  input  logic [AW-1:0] wr_idx_i [rename_pkg::SLOTS],
  input  logic [PW-1:0] wr_tag_i [rename_pkg::SLOTS]
);
  logic [PW-1:0] map_q [ARCH_N];
  logic [PW-1:0] map_d [ARCH_N];

  // later port wins: slot 1 is younger in program order
  always_comb begin
    map_d = map_q;
    for (int p = 0; p < int'(rename_pkg::SLOTS); p++) begin
      if (wr_en_i[p]) map_d[wr_idx_i[p]] = wr_tag_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ARCH_N); i++) map_q[i] <= PW'(i);
    end else begin
      map_q <= map_d;
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rd_tag_o[g] = (rd_idx_i[g] == '0) ? '0 : map_q[rd_idx_i[g]];
  end
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int unsigned ARCH_N = rename_pkg::DEF_ARCH_N,
  parameter int unsigned PHYS_N = rename_pkg::DEF_PHYS_N,
  localparam int unsigned PW    = $clog2(PHYS_N),
  localparam int unsigned CW    = PW + 1,
  localparam int unsigned FREE0 = PHYS_N - ARCH_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    pop_cnt_i,
  input  logic          push_en_i  [rename_pkg::SLOTS],
  input  logic [PW-1:0] push_tag_i [rename_pkg::SLOTS],
  output logic [PW-1:0] head0_o,
  output logic [PW-1:0] head1_o,
  output logic [CW-1:0] count_o
);
  logic [PW-1:0] mem_q [PHYS_N];
  logic [PW-1:0] mem_d [PHYS_N];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wr_ptr;

  always_comb begin
    mem_d  = mem_q;
    wr_ptr = tail_q;
    for (int p = 0; p < int'(rename_pkg::SLOTS); p++) begin
      if (push_en_i[p]) begin
        mem_d[wr_ptr] = push_tag_i[p];
        wr_ptr        = wr_ptr + PW'(1);
      end
    end
    tail_d = wr_ptr;
    head_d = head_q + PW'(pop_cnt_i);
    cnt_d  = cnt_q - CW'(pop_cnt_i) + CW'(push_en_i[0]) + CW'(push_en_i[1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(PHYS_N); i++)
        mem_q[i] <= (i < int'(FREE0)) ? PW'(i + int'(ARCH_N)) : '0;
      head_q <= '0;
      tail_q <= PW'(FREE0);
      cnt_q  <= CW'(FREE0);
    end else begin
      mem_q  <= mem_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head0_o = mem_q[head_q];
  assign head1_o = mem_q[head_q + PW'(1)];
  assign count_o = cnt_q;
endmodule

// File: rtl/rename_steer.sv
module rename_steer #(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6,
  localparam int unsigned CW = PW + 1
) (
  input  logic          v0_i, we0_i, v1_i, we1_i,
  input  logic [AW-1:0] d0_i, d1_i, s1a_i, s1b_i,
  input  logic [PW-1:0] t_s0a_i, t_s0b_i, t_s1a_i, t_s1b_i, t_d0_i, t_d1_i,
  input  logic [PW-1:0] fl_h0_i, fl_h1_i,
  input  logic [CW-1:0] fl_cnt_i,
  output logic          stall_o, ok0_o, ok1_o,
  output logic [PW-1:0] s0a_o, s0b_o, s1a_o, s1b_o,
  output logic [PW-1:0] dst0_o, dst1_o, prev0_o, prev1_o,
  output logic [1:0]    pop_cnt_o,
  output logic          wr0_o, wr1_o
);
  logic       alloc0, alloc1, go;
  logic [1:0] need;
  logic [PW-1:0] new0, new1;

  always_comb begin
    alloc0  = v0_i & we0_i & (d0_i != '0);
    alloc1  = v1_i & we1_i & (d1_i != '0);
    need    = {1'b0, alloc0} + {1'b0, alloc1};
    stall_o = CW'(need) > fl_cnt_i;
    go      = ~stall_o;
    ok0_o   = v0_i & go;
    ok1_o   = v1_i & go;

    new0    = fl_h0_i;
    new1    = alloc0 ? fl_h1_i : fl_h0_i;

    s0a_o   = t_s0a_i;
    s0b_o   = t_s0b_i;
    s1a_o   = (alloc0 && s1a_i == d0_i) ? new0 : t_s1a_i;
    s1b_o   = (alloc0 && s1b_i == d0_i) ? new0 : t_s1b_i;

    dst0_o  = alloc0 ? new0 : '0;
    dst1_o  = alloc1 ? new1 : '0;
    prev0_o = alloc0 ? t_d0_i : '0;
    prev1_o = '0;
    if (alloc1) prev1_o = (alloc0 && d1_i == d0_i) ? new0 : t_d1_i;

    pop_cnt_o = go ? need : 2'd0;
    wr0_o     = go & alloc0;
    wr1_o     = go & alloc1;
  end
endmodule

// File: rtl/rename2_stage.sv
module rename2_stage #(
  parameter int unsigned ARCH_N = rename_pkg::DEF_ARCH_N,
  parameter int unsigned PHYS_N = rename_pkg::DEF_PHYS_N,
  localparam int unsigned AW    = $clog2(ARCH_N),
  localparam int unsigned PW    = $clog2(PHYS_N),
  localparam int unsigned CW    = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s0_valid_i,
  input  logic [AW-1:0] s0_src_a_i,
  input  logic [AW-1:0] s0_src_b_i,
  input  logic [AW-1:0] s0_dst_i,
  input  logic          s0_wen_i,
  input  logic          s1_valid_i,
  input  logic [AW-1:0] s1_src_a_i,
  input  logic [AW-1:0] s1_src_b_i,
  input  logic [AW-1:0] s1_dst_i,
  input  logic          s1_wen_i,
  input  logic          rel0_en_i,
  input  logic [PW-1:0] rel0_tag_i,
  input  logic          rel1_en_i,
  input  logic [PW-1:0] rel1_tag_i,
  output logic          stall_o,
  output logic          s0_ok_o,
  output logic [PW-1:0] s0_src_a_tag_o,
  output logic [PW-1:0] s0_src_b_tag_o,
  output logic [PW-1:0] s0_dst_tag_o,
  output logic [PW-1:0] s0_prev_tag_o,
  output logic          s1_ok_o,
  output logic [PW-1:0] s1_src_a_tag_o,
  output logic [PW-1:0] s1_src_b_tag_o,
  output logic [PW-1:0] s1_dst_tag_o,
  output logic [PW-1:0] s1_prev_tag_o
);
  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [AW-1:0] rd_idx [rename_pkg::RD_PORTS];
  logic [PW-1:0] rd_tag [rename_pkg::RD_PORTS];
  logic          wr_en  [rename_pkg::SLOTS];
  logic [AW-1:0] wr_idx [rename_pkg::SLOTS];
  logic [PW-1:0] wr_tag [rename_pkg::SLOTS];
  logic          rel_en [rename_pkg::SLOTS];
  logic [PW-1:0] rel_tag[rename_pkg::SLOTS];
  logic [PW-1:0] fl_h0, fl_h1;
  logic [CW-1:0] fl_cnt;
  logic [1:0]    pop_cnt;
  logic          wr0, wr1;

  assign rd_idx[0] = s0_src_a_i;
  assign rd_idx[1] = s0_src_b_i;
  assign rd_idx[2] = s1_src_a_i;
  assign rd_idx[3] = s1_src_b_i;
  assign rd_idx[4] = s0_dst_i;
  assign rd_idx[5] = s1_dst_i;

  assign wr_en[0]  = wr0;
  assign wr_en[1]  = wr1;
  assign wr_idx[0] = s0_dst_i;
  assign wr_idx[1] = s1_dst_i;
  assign wr_tag[0] = s0_dst_tag_o;
  assign wr_tag[1] = s1_dst_tag_o;

  assign rel_en[0]  = rel0_en_i;
  assign rel_en[1]  = rel1_en_i;
  assign rel_tag[0] = rel0_tag_i;
  assign rel_tag[1] = rel1_tag_i;

  rename_maptable #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) i_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .rd_idx_i (rd_idx),
    .rd_tag_o (rd_tag),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_tag_i (wr_tag)
  );

  rename_freelist #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) i_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .pop_cnt_i  (pop_cnt),
    .push_en_i  (rel_en),
    .push_tag_i (rel_tag),
    .head0_o    (fl_h0),
    .head1_o    (fl_h1),
    .count_o    (fl_cnt)
  );

  rename_steer #(.AW(AW), .PW(PW)) i_steer (
    .v0_i      (s0_valid_i),
    .we0_i     (s0_wen_i),
    .v1_i      (s1_valid_i),
    .we1_i     (s1_wen_i),
    .d0_i      (s0_dst_i),
    .d1_i      (s1_dst_i),
    .s1a_i     (s1_src_a_i),
    .s1b_i     (s1_src_b_i),
    .t_s0a_i   (rd_tag[0]),
    .t_s0b_i   (rd_tag[1]),
    .t_s1a_i   (rd_tag[2]),
    .t_s1b_i   (rd_tag[3]),
    .t_d0_i    (rd_tag[4]),
    .t_d1_i    (rd_tag[5]),
    .fl_h0_i   (fl_h0),
    .fl_h1_i   (fl_h1),
    .fl_cnt_i  (fl_cnt),
    .stall_o   (stall_o),
    .ok0_o     (s0_ok_o),
    .ok1_o     (s1_ok_o),
    .s0a_o     (s0_src_a_tag_o),
    .s0b_o     (s0_src_b_tag_o),
    .s1a_o     (s1_src_a_tag_o),
    .s1b_o     (s1_src_b_tag_o),
    .dst0_o    (s0_dst_tag_o),
    .dst1_o    (s1_dst_tag_o),
    .prev0_o   (s0_prev_tag_o),
    .prev1_o   (s1_prev_tag_o),
    .pop_cnt_o (pop_cnt),
    .wr0_o     (wr0),
    .wr1_o     (wr1)
  );
endmodule

// File: rtl/rename2_checks.sv
module rename2_checks #(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s0_valid_i,
  input logic [AW-1:0] s0_src_a_i,
  input logic [AW-1:0] s0_dst_i,
  input logic          s0_wen_i,
  input logic          s1_valid_i,
  input logic [AW-1:0] s1_dst_i,
  input logic          s1_wen_i,
  input logic          stall_o,
  input logic          s0_ok_o,
  input logic [PW-1:0] s0_src_a_tag_o,
  input logic [PW-1:0] s0_dst_tag_o,
  input logic          s1_ok_o,
  input logic [PW-1:0] s1_dst_tag_o,
  input logic [PW-1:0] s1_prev_tag_o
);
  // R8
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!s0_ok_o && !s1_ok_o));

  // R10
  ok_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s0_valid_i || !s1_valid_i) |-> ((!s0_valid_i -> !s0_ok_o) && (!s1_valid_i -> !s1_ok_o)));

  // R3
  twin_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_ok_o && s1_ok_o && s0_wen_i && s1_wen_i && s0_dst_i == s1_dst_i && s0_dst_i != '0)
    |-> (s0_dst_tag_o != s1_dst_tag_o && s1_prev_tag_o == s0_dst_tag_o));

  // R7
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_ok_o && s0_src_a_i == '0) |-> s0_src_a_tag_o == '0);

  // R2
  fresh_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_ok_o && s0_wen_i && s0_dst_i != '0) |-> s0_dst_tag_o != '0);

  // R5
  read_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s0_ok_o && s0_wen_i && s0_dst_i != '0 &&
      !(s1_valid_i && s1_wen_i && s1_dst_i == s0_dst_i))
     ##1 (s0_ok_o && s0_src_a_i == $past(s0_dst_i)))
    |-> s0_src_a_tag_o == $past(s0_dst_tag_o));
endmodule

bind rename2_stage rename2_checks #(.AW(AW), .PW(PW)) i_chk (.*);

// File: tb/test_rename2_stage.sv
module test_rename2_stage;
  localparam int CLK_PERIOD = 10;
  localparam int ARCH_N = 32;
  localparam int PHYS_N = 64;
  localparam int AW = $clog2(ARCH_N);
  localparam int PW = $clog2(PHYS_N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          s0_valid, s0_wen, s1_valid, s1_wen, rel0_en, rel1_en;
  logic [AW-1:0] s0_a, s0_b, s0_d, s1_a, s1_b, s1_d;
  logic [PW-1:0] rel0_tag, rel1_tag;
  logic          stall, ok0, ok1;
  logic [PW-1:0] t0a, t0b, t0d, t0p, t1a, t1b, t1d, t1p;

  rename2_stage #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) i_rename2_stage (
    .clk_i(clk), .rst_ni(rst_n),
    .s0_valid_i(s0_valid), .s0_src_a_i(s0_a), .s0_src_b_i(s0_b),
    .s0_dst_i(s0_d), .s0_wen_i(s0_wen),
    .s1_valid_i(s1_valid), .s1_src_a_i(s1_a), .s1_src_b_i(s1_b),
    .s1_dst_i(s1_d), .s1_wen_i(s1_wen),
    .rel0_en_i(rel0_en), .rel0_tag_i(rel0_tag),
    .rel1_en_i(rel1_en), .rel1_tag_i(rel1_tag),
    .stall_o(stall),
    .s0_ok_o(ok0), .s0_src_a_tag_o(t0a), .s0_src_b_tag_o(t0b),
    .s0_dst_tag_o(t0d), .s0_prev_tag_o(t0p),
    .s1_ok_o(ok1), .s1_src_a_tag_o(t1a), .s1_src_b_tag_o(t1b),
    .s1_dst_tag_o(t1d), .s1_prev_tag_o(t1p)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int map_m [ARCH_N];
  int fq[$];
  int pend[$];

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int rd(input int a);
    return (a == 0) ? 0 : map_m[a];
  endfunction

  // one cycle: drive after the falling edge, compare, then advance the model
  task automatic go(input bit v0, input int a0, input int b0, input int d0, input bit w0,
                    input bit v1, input int a1, input int b1, input int d1, input bit w1,
                    input bit f0, input bit f1);
    int need, ea, eb, ed, ep;
    bit al0, al1, est;
    int r0, r1;
    bit e0, e1;
    @(negedge clk);
    e0 = f0 && pend.size() > 0;
    r0 = e0 ? pend.pop_front() : 0;
    e1 = f1 && pend.size() > 0;
    r1 = e1 ? pend.pop_front() : 0;
    s0_valid = v0; s0_a = AW'(a0); s0_b = AW'(b0); s0_d = AW'(d0); s0_wen = w0;
    s1_valid = v1; s1_a = AW'(a1); s1_b = AW'(b1); s1_d = AW'(d1); s1_wen = w1;
    rel0_en = e0; rel0_tag = PW'(r0); rel1_en = e1; rel1_tag = PW'(r1);
    #1;
    al0 = v0 && w0 && d0 != 0;
    al1 = v1 && w1 && d1 != 0;
    need = int'(al0) + int'(al1);
    est = need > fq.size();
    chk(int'(stall), int'(est), "R8", "stall");
    chk(int'(ok0), int'(v0 && !est), "R10", "ok0");
    chk(int'(ok1), int'(v1 && !est), "R10", "ok1");
    if (!est && v0) begin
      ea = rd(a0); eb = rd(b0);
      ed = 0; ep = 0;
      if (al0) begin ep = map_m[d0]; ed = fq.pop_front(); map_m[d0] = ed; pend.push_back(ep); end
      chk(int'(t0a), ea, (a0 == 0) ? "R7" : "R5", "s0 src a");
      chk(int'(t0b), eb, (b0 == 0) ? "R7" : "R5", "s0 src b");
      chk(int'(t0d), ed, al0 ? "R2" : "R10", "s0 dst");
      chk(int'(t0p), ep, "R6", "s0 prev");
    end
    if (!est && v1) begin
      ea = rd(a1); eb = rd(b1);
      ed = 0; ep = 0;
      if (al1) begin ep = map_m[d1]; ed = fq.pop_front(); map_m[d1] = ed; pend.push_back(ep); end
      chk(int'(t1a), ea, (a1 == 0) ? "R7" : (al0 && a1 == d0) ? "R4" : "R5", "s1 src a");
      chk(int'(t1b), eb, (b1 == 0) ? "R7" : (al0 && b1 == d0) ? "R4" : "R5", "s1 src b");
      chk(int'(t1d), ed, al1 ? "R2" : "R10", "s1 dst");
      chk(int'(t1p), ep, "R6", "s1 prev");
    end
    if (e0) fq.push_back(r0);
    if (e1) fq.push_back(r1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    s0_valid = 0; s0_a = '0; s0_b = '0; s0_d = '0; s0_wen = 0;
    s1_valid = 0; s1_a = '0; s1_b = '0; s1_d = '0; s1_wen = 0;
    rel0_en = 0; rel0_tag = '0; rel1_en = 0; rel1_tag = '0;
    for (int i = 0; i < ARCH_N; i++) map_m[i] = i;
    for (int t = ARCH_N; t < PHYS_N; t++) fq.push_back(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) go(0,0,0,0,0, 0,0,0,0,0, 0,0);
    chk(int'(stall), 0, "R8", "reset stall");

    // R1: identity mapping after reset
    go(1,3,7,0,0, 1,0,31,0,0, 0,0);
    chk(int'(t0a), 3, "R1", "read r3");
    chk(int'(t1b), 31, "R1", "read r31");

    // R3 R4: same destination in both slots, slot 1 reads it
    go(1,1,2,4,1, 1,4,4,4,1, 0,0);
    chk(int'(t0d), 32, "R2", "first fresh tag");
    chk(int'(t1d), 33, "R3", "second tag distinct");
    chk(int'(t1a), 32, "R4", "slot 1 sees slot 0 tag");
    chk(int'(t1p), 32, "R6", "slot 1 prev is slot 0 tag");
    go(1,4,0,0,0, 0,0,0,0,0, 0,0);
    chk(int'(t0a), 33, "R3", "table keeps slot 1 tag");

    // R7: write to register 0 allocates nothing
    go(1,0,0,0,1, 1,0,0,9,1, 0,0);
    chk(int'(t0d), 0, "R7", "r0 dst tag");
    chk(int'(t1d), 34, "R7", "next tag not consumed by r0");

    // R8: drain the free list (29 left) down to one
    for (int k = 0; k < 14; k++) go(1,0,0,1 + (k % 3),1, 1,0,0,5 + (k % 3),1, 0,0);
    go(1,0,0,20,1, 1,0,0,21,1, 0,0);
    chk(int'(stall), 1, "R8", "stall with one free tag");
    go(1,20,21,0,0, 0,0,0,0,0, 0,0);
    chk(int'(t0a), 20, "R8", "map untouched by stalled group");
    go(0,0,0,0,0, 1,0,0,20,1, 0,0);
    chk(int'(t1d), 63, "R8", "free list untouched by stall");

    // R9: released tags come back in release order
    go(0,0,0,0,0, 0,0,0,0,0, 1,1);
    go(1,0,0,11,1, 1,0,0,12,1, 0,0);
    chk(int'(t0d), 4, "R9", "first released tag");
    chk(int'(t1d), 32, "R9", "second released tag");

    // random mix with narrow register range
    for (int n = 0; n < 3000; n++) begin
      go($urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,1),
         $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,1),
         ($urandom_range(0,3) != 0), ($urandom_range(0,2) == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule